// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is ready for normal traffic. It holds clock-enable and the data masks high, drives no-operation commands through a long, programmable stabilisation wait, and then issues the mandatory start-up commands. These are a precharge of every bank, a run of auto-refresh commands and a load of the mode register. It spaces the commands with the row-precharge and row-cycle clock counts supplied at its inputs.

When the last command has settled it raises `init_done`. A normal memory controller then takes over the pins. The stabilisation wait is a cycle count, so the integrator sets it to cover at least 200 microseconds at the chosen clock. A configuration bit, latched while reset is held, picks whether the mode-register load comes before or after the refreshes. The number of refreshes is a parameter, and it must be at least two.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is held, and on every cycle after it, `sd_cke` is 1 and every bit of `sd_dqm` is 1. While reset is held, the pins show NOP and `init_done` is 0. NOP is `sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1.
- R2: Cycle index 0 is the first cycle after the first rising edge at which `rst_n` is high. The cycles at index 0 through `cfg_wait_cycles`-1 show NOP. The precharge-all command appears at index `cfg_wait_cycles`. It is encoded as `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=0, with `sd_addr[10]`=1 and `sd_ba`=0.
- R3: The command that follows the precharge-all appears max(`cfg_trp`,1) cycles after it, so a value of 0 acts as 1.
- R4: Exactly NUM_AREF auto-refresh commands are issued. Each is encoded as `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=0, `sd_we_n`=1. Whatever follows a refresh appears max(`cfg_trc`,1) cycles after it: the next command, or the rise of `init_done`.
- R5: The mode-register load is encoded with `sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` all 0 and `sd_ba`=0. `sd_addr` equals `cfg_mode_word` with bits 11, 10, 8 and 7 forced to 0, so the address carries bit 9 and bits 6..0 of the word (bits 6..4 hold the CAS latency: 010 for 2, 011 for 3).
- R6: `cfg_mrs_first` is taken while reset is held. A value of 1 gives the order precharge, mode load, refreshes. A value of 0 gives the order precharge, refreshes, mode load. Changing the input after reset has no effect on the order.
- R7: Whatever follows the mode-register load appears exactly 2 cycles after it: the first refresh, or the rise of `init_done`.
- R8: Every cycle other than the issued commands shows NOP. Once `init_done` rises, it stays 1 and the pins stay NOP until the next reset.
- R9: Between reset and `init_done`, exactly NUM_AREF+2 commands are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| cfg_wait_cycles | input | WAIT_W | Number of NOP cycles before the precharge-all |
| cfg_trp | input | TIM_W | Row-precharge spacing in clocks (0 treated as 1) |
| cfg_trc | input | TIM_W | Row-cycle spacing after each refresh in clocks (0 treated as 1) |
| cfg_mode_word | input | ADDR_W | Mode word placed on the address during the mode load |
| cfg_mrs_first | input | 1 | Order select, latched during reset: 1 = mode load before refreshes |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (A10 = all-bank flag during precharge) |
| sd_ba | output | BANK_W | Bank select, 0 for every issued command |
| sd_dqm | output | DQM_W | Data masks, held high |
| init_done | output | 1 | High once the sequence has finished; sticky until reset |

## Verification
The assertions take the timing and mode inputs to be steady from reset until `init_done`, because the spacing checks read `cfg_trp` and `cfg_trc` directly. They also take the mode-field positions to be those of a 12-bit address. The stimulus changes every configuration input only while reset is held. The one exception is `cfg_mrs_first`, which the bench flips on purpose right after reset release to show that the latched order wins. Random cases draw waits, both spacings including the zero clamp, mode words and order bits. Directed cases add back-to-back spacing, maximum spacing and a full 200-microsecond wait.

// File: rtl/sdram_boot_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes a single-data-rate SDRAM command set with active-low strobes.
package sdram_boot_pkg;

    // Commands the sequencer can place on the pins.
    typedef enum logic [1:0] {
        BOOT_CMD_NOP     = 2'd0,
        BOOT_CMD_PRE_ALL = 2'd1,
        BOOT_CMD_AREF    = 2'd2,
        BOOT_CMD_MRS     = 2'd3
    } boot_cmd_e;

    // Steps of the start-up sequence; each names the command issued next.
    typedef enum logic [1:0] {
        BST_PRECH = 2'd0,
        BST_AREF  = 2'd1,
        BST_MRS   = 2'd2,
        BST_DONE  = 2'd3
    } boot_state_e;

    // Strobe pins as a group.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } boot_pins_t;

    // Cycles from a mode-register load to the next command.
    localparam int unsigned MRS_SETTLE_CYC = 2;

    // Maps a command to its strobe levels.
    function automatic boot_pins_t boot_encode(boot_cmd_e cmd);
        boot_pins_t p;
        p.cs_n = 1'b0;
        unique case (cmd)
            BOOT_CMD_PRE_ALL: begin p.ras_n = 1'b0; p.cas_n = 1'b1; p.we_n = 1'b0; end
            BOOT_CMD_AREF:    begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.we_n = 1'b1; end
            BOOT_CMD_MRS:     begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.we_n = 1'b0; end
            default:          begin p.ras_n = 1'b1; p.cas_n = 1'b1; p.we_n = 1'b1; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/boot_gap_timer.sv
// Down-counting spacing timer.
// During reset it takes the stabilisation wait. After reset it reloads
// whenever a command is issued and counts down to zero otherwise.
// Assumes the reset value is steady while rst_n is low.
module boot_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rst_val_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Counter: preset in reset, reload on issue, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= rst_val_i;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/boot_step_fsm.sv
// Step machine of the start-up sequence.
// When the spacing timer has expired it issues the command of the current
// step, gives the timer the spacing that must follow, and advances.
// The step order comes from an order bit latched during reset.
// Assumes trp_eff_i and trc_eff_i are at least 1.
module boot_step_fsm
    import sdram_boot_pkg::*;
#(
    parameter int NUM_AREF = 2,
    parameter int TIM_W    = 4,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_first_i,
    input  logic [TIM_W-1:0] trp_eff_i,
    input  logic [TIM_W-1:0] trc_eff_i,
    input  logic             expired_i,
    output logic             issue_o,
    output boot_cmd_e        cmd_o,
    output logic [CNT_W-1:0] gap_o,
    output logic             done_o
);

    localparam int AREF_W = $clog2(NUM_AREF + 1);
    localparam logic [AREF_W-1:0] AREF_LAST = AREF_W'(NUM_AREF - 1);

    boot_state_e       state_q, state_d;
    logic [AREF_W-1:0] aref_q;
    logic              order_q;
    logic              done_q;

    // Next step, command and spacing for the current cycle.
    always_comb begin
        state_d = state_q;
        cmd_o   = BOOT_CMD_NOP;
        gap_o   = '0;
        issue_o = expired_i && (state_q != BST_DONE);
        if (issue_o) begin
            unique case (state_q)
                BST_PRECH: begin
                    cmd_o   = BOOT_CMD_PRE_ALL;
                    gap_o   = CNT_W'(trp_eff_i) - CNT_W'(1);
                    state_d = order_q ? BST_MRS : BST_AREF;
                end
                BST_AREF: begin
                    cmd_o = BOOT_CMD_AREF;
                    gap_o = CNT_W'(trc_eff_i) - CNT_W'(1);
                    if (aref_q == AREF_LAST) begin
                        state_d = order_q ? BST_DONE : BST_MRS;
                    end
                end
                BST_MRS: begin
                    cmd_o   = BOOT_CMD_MRS;
                    gap_o   = CNT_W'(MRS_SETTLE_CYC - 1);
                    state_d = order_q ? BST_AREF : BST_DONE;
                end
                default: begin
                    cmd_o = BOOT_CMD_NOP;
                end
            endcase
        end
    end

    // Step register; starts at the precharge step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BST_PRECH;
        else        state_q <= state_d;
    end

    // Order bit, captured only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= mrs_first_i;
    end

    // Count of refreshes issued so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aref_q <= '0;
        end else if (issue_o && (state_q == BST_AREF)) begin
            aref_q <= aref_q + 1'b1;
        end
    end

    // Ready flag: set once the final spacing has run out, sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if ((state_q == BST_DONE) && expired_i) begin
            done_q <= 1'b1;
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/boot_pin_driver.sv
// Registered SDRAM pin stage.
// It turns the command of each cycle into strobe, address and bank levels.
// Clock enable and masks stay high for the whole sequence.
// The mode word goes out with its reserved fields (bits 11..10, 8..7)
// cleared. Assumes ADDR_W >= 11 so that the all-bank flag bit exists.
module boot_pin_driver
    import sdram_boot_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int DQM_W  = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  boot_cmd_e         cmd_i,
    input  logic [ADDR_W-1:0] mode_word_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [DQM_W-1:0]  dqm_o
);

    logic [ADDR_W-1:0] mode_keep;
    logic [ADDR_W-1:0] addr_d;
    boot_pins_t        pins_d, pins_q;

    // Keep mask for the mode word: clear bits 7, 8 and 10 upward.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mode_mask
        if ((i == 7) || (i == 8) || (i >= 10)) begin : g_clr
            assign mode_keep[i] = 1'b0;
        end else begin : g_keep
            assign mode_keep[i] = 1'b1;
        end
    end

    // Address and strobe levels for the command of this cycle.
    always_comb begin
        pins_d = boot_encode(cmd_i);
        addr_d = '0;
        unique case (cmd_i)
            BOOT_CMD_PRE_ALL: addr_d[AP_BIT] = 1'b1;
            BOOT_CMD_MRS:     addr_d = mode_word_i & mode_keep;
            default:          addr_d = '0;
        endcase
    end

    // Output registers; NOP and zero address while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= boot_encode(BOOT_CMD_NOP);
            addr_o <= '0;
        end else begin
            pins_q <= pins_d;
            addr_o <= addr_d;
        end
    end

    assign cs_n_o  = pins_q.cs_n;
    assign ras_n_o = pins_q.ras_n;
    assign cas_n_o = pins_q.cas_n;
    assign we_n_o  = pins_q.we_n;
    assign ba_o    = '0;
    assign cke_o   = 1'b1;
    assign dqm_o   = '1;

endmodule

// File: rtl/sdram_boot_seq.sv
// SDRAM power-up sequencer, top level.
// It drives NOP for cfg_wait_cycles cycles, then issues a precharge-all,
// NUM_AREF refreshes and one mode-register load, in the order chosen at
// reset. It then raises init_done.
// Assumes the cfg_* inputs are steady from reset until init_done.
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int WAIT_W   = 16,
    parameter int TIM_W    = 4,
    parameter int NUM_AREF = 2,
    parameter int ADDR_W   = 12,
    parameter int BANK_W   = 2,
    parameter int DQM_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_wait_cycles,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic [TIM_W-1:0]  cfg_trc,
    input  logic [ADDR_W-1:0] cfg_mode_word,
    input  logic              cfg_mrs_first,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);

    localparam int CNT_W = (WAIT_W > TIM_W) ? WAIT_W : TIM_W;

    if (NUM_AREF < 2) begin : g_bad_aref
        $error("NUM_AREF must be at least 2");
    end

    logic [TIM_W-1:0] trp_eff, trc_eff;
    logic             expired, issue;
    logic [CNT_W-1:0] gap;
    boot_cmd_e        cmd;

    // Zero spacing is treated as one cycle.
    assign trp_eff = (cfg_trp == '0) ? TIM_W'(1) : cfg_trp;
    assign trc_eff = (cfg_trc == '0) ? TIM_W'(1) : cfg_trc;

    boot_gap_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_val_i (CNT_W'(cfg_wait_cycles)),
        .load_i    (issue),
        .load_val_i(gap),
        .expired_o (expired)
    );

    boot_step_fsm #(
        .NUM_AREF(NUM_AREF),
        .TIM_W   (TIM_W),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrs_first_i(cfg_mrs_first),
        .trp_eff_i  (trp_eff),
        .trc_eff_i  (trc_eff),
        .expired_i  (expired),
        .issue_o    (issue),
        .cmd_o      (cmd),
        .gap_o      (gap),
        .done_o     (init_done)
    );

    boot_pin_driver #(
        .ADDR_W(ADDR_W),
        .BANK_W(BANK_W),
        .DQM_W (DQM_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .mode_word_i(cfg_mode_word),
        .cke_o      (sd_cke),
        .cs_n_o     (sd_cs_n),
        .ras_n_o    (sd_ras_n),
        .cas_n_o    (sd_cas_n),
        .we_n_o     (sd_we_n),
        .addr_o     (sd_addr),
        .ba_o       (sd_ba),
        .dqm_o      (sd_dqm)
    );

endmodule

// File: rtl/sdram_boot_seq_chk.sv
// Protocol checker for the SDRAM power-up sequencer.
// It decodes the pins and tracks the last command, the cycles since it and
// the commands seen so far. It then checks spacing, encoding and
// completion. Assumes cfg_trp and cfg_trc are steady after reset and a
// 12-bit mode-field layout.
module sdram_boot_seq_chk #(
    parameter int TIM_W    = 4,
    parameter int ADDR_W   = 12,
    parameter int NUM_AREF = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIM_W-1:0]  cfg_trp,
    input logic [TIM_W-1:0]  cfg_trc,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);

    logic [2:0]  strobes;
    logic        is_pre, is_aref, is_mrs, is_cmd;
    logic [1:0]  last_kind;
    logic [15:0] since_last;
    logic [7:0]  aref_seen;
    logic        mrs_seen;
    logic [15:0] trp_min, trc_min;

    assign strobes = {sd_ras_n, sd_cas_n, sd_we_n};
    assign is_pre  = !sd_cs_n && (strobes == 3'b010);
    assign is_aref = !sd_cs_n && (strobes == 3'b001);
    assign is_mrs  = !sd_cs_n && (strobes == 3'b000);
    assign is_cmd  = !sd_cs_n && (strobes != 3'b111);
    assign trp_min = (cfg_trp == '0) ? 16'd1 : 16'(cfg_trp);
    assign trc_min = (cfg_trc == '0) ? 16'd1 : 16'(cfg_trc);

    // Last command kind (1 pre, 2 refresh, 3 mode) and cycles since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_kind  <= 2'd0;
            since_last <= 16'd0;
        end else if (is_cmd) begin
            last_kind  <= is_pre ? 2'd1 : (is_aref ? 2'd2 : 2'd3);
            since_last <= 16'd1;
        end else if (since_last != 16'hFFFF) begin
            since_last <= since_last + 16'd1;
        end
    end

    // Running totals of refreshes and mode loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aref_seen <= 8'd0;
            mrs_seen  <= 1'b0;
        end else begin
            if (is_aref && aref_seen != 8'hFF) aref_seen <= aref_seen + 8'd1;
            if (is_mrs) mrs_seen <= 1'b1;
        end
    end

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]); // R2

    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_kind == 2'd1) |-> since_last >= trp_min); // R3

    AST_AREF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_kind == 2'd2) |-> since_last >= trc_min); // R4

    AST_AREF_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(init_done) && last_kind == 2'd2) |-> since_last >= trc_min); // R4

    AST_MRS_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00)); // R5

    AST_MRS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> (!init_done && !is_cmd)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !is_cmd); // R8

    AST_DONE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (mrs_seen && aref_seen >= 8'(NUM_AREF))); // R9

endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .TIM_W   (TIM_W),
    .ADDR_W  (ADDR_W),
    .NUM_AREF(NUM_AREF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_trp  (cfg_trp),
    .cfg_trc  (cfg_trc),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .init_done(init_done)
);

// File: tb/sdram_boot_seq_tb.sv
`timescale 1ns/1ps
// Bench for the SDRAM power-up sequencer.
// Each case sets the configuration under reset and releases reset. It then
// logs every command seen at the pins, with its cycle index, and compares
// the log with a schedule computed from the requirements.
module sdram_boot_seq_tb;

    localparam int WAIT_W   = 16;
    localparam int TIM_W    = 4;
    localparam int NUM_AREF = 2;
    localparam int ADDR_W   = 12;
    localparam int N_EXP    = NUM_AREF + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WAIT_W-1:0] cfg_wait_cycles = '0;
    logic [TIM_W-1:0]  cfg_trp = '0;
    logic [TIM_W-1:0]  cfg_trc = '0;
    logic [ADDR_W-1:0] cfg_mode_word = '0;
    logic              cfg_mrs_first = 1'b0;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [1:0]        sd_ba;
    logic [1:0]        sd_dqm;
    logic              init_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdram_boot_seq #(
        .WAIT_W(WAIT_W), .TIM_W(TIM_W), .NUM_AREF(NUM_AREF), .ADDR_W(ADDR_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wait_cycles(cfg_wait_cycles),
        .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .cfg_mode_word(cfg_mode_word),
        .cfg_mrs_first(cfg_mrs_first), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .init_done(init_done)
    );

    // Pass/fail bookkeeping for one check.
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pin decode: 0 NOP, 1 precharge-all, 2 refresh, 3 mode load, 4 other.
    function automatic int decode();
        if (sd_cs_n || {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111) return 0;
        case ({sd_ras_n, sd_cas_n, sd_we_n})
            3'b010:  return 1;
            3'b001:  return 2;
            3'b000:  return 3;
            default: return 4;
        endcase
    endfunction

    // Requirement tag for the spacing after a given command kind.
    function automatic string gap_req(input int kind);
        if (kind == 1) return "R3";
        if (kind == 2) return "R4";
        return "R7";
    endfunction

    task automatic run_case(input int w, input int trp, input int trc,
                            input logic [ADDR_W-1:0] mw, input bit mf);
        int k_log[16];
        int i_log[16];
        int a_log[16];
        int b_log[16];
        int n = 0;
        int done_idx = -1;
        int pin_bad = 0;
        int e_kind[N_EXP];
        int e_idx[N_EXP];
        int e_done;
        int trp_e, trc_e, t;
        int lim;

        @(negedge clk);
        rst_n = 1'b0;
        cfg_wait_cycles = WAIT_W'(w);
        cfg_trp = TIM_W'(trp);
        cfg_trc = TIM_W'(trc);
        cfg_mode_word = mw;
        cfg_mrs_first = mf;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(decode() == 0, "R1", "reset pins cmd", decode(), 0);
        check(sd_cke && sd_dqm == 2'b11, "R1", "reset cke/dqm",
              int'({sd_cke, sd_dqm}), 7);
        check(!init_done, "R1", "reset init_done", int'(init_done), 0);

        rst_n = 1'b1;
        lim = w + 100;
        for (int idx = 0; idx < lim; idx++) begin
            @(negedge clk);
            if (idx == 0) cfg_mrs_first = ~mf;   // R6: must not change the order
            if (!sd_cke || sd_dqm != 2'b11) pin_bad++;
            if (init_done) begin
                done_idx = idx;
                break;
            end
            if (decode() != 0) begin
                if (n < 16) begin
                    k_log[n] = decode();
                    i_log[n] = idx;
                    a_log[n] = int'(sd_addr);
                    b_log[n] = int'(sd_ba);
                end
                n++;
            end
        end
        // R8: after ready, flag held and pins quiet
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            if (!sd_cke || sd_dqm != 2'b11) pin_bad++;
            check(init_done == 1'b1, "R8", "init_done held", int'(init_done), 1);
            check(decode() == 0, "R8", "NOP after done", decode(), 0);
        end
        check(pin_bad == 0, "R1", "cycles with cke/dqm low", pin_bad, 0);

        // Expected schedule from the requirements
        trp_e = (trp == 0) ? 1 : trp;
        trc_e = (trc == 0) ? 1 : trc;
        e_kind[0] = 1;
        e_idx[0] = w;
        t = w + trp_e;
        if (mf) begin
            e_kind[1] = 3; e_idx[1] = t; t += 2;
            for (int r = 0; r < NUM_AREF; r++) begin
                e_kind[2 + r] = 2; e_idx[2 + r] = t; t += trc_e;
            end
        end else begin
            for (int r = 0; r < NUM_AREF; r++) begin
                e_kind[1 + r] = 2; e_idx[1 + r] = t; t += trc_e;
            end
            e_kind[N_EXP - 1] = 3; e_idx[N_EXP - 1] = t; t += 2;
        end
        e_done = t;

        check(n == N_EXP, "R9", "command count", n, N_EXP);
        for (int i = 0; i < N_EXP && i < n && i < 16; i++) begin
            check(k_log[i] == e_kind[i], (i == 0) ? "R2" : "R6", "command kind",
                  k_log[i], e_kind[i]);
            check(i_log[i] == e_idx[i], (i == 0) ? "R2" : gap_req(e_kind[i - 1]),
                  "command cycle", i_log[i], e_idx[i]);
            check(b_log[i] == 0, "R5", "bank bits", b_log[i], 0);
            if (e_kind[i] == 1)
                check(a_log[i][10] == 1'b1, "R2", "precharge A10", a_log[i], 1024);
            if (e_kind[i] == 3)
                check(a_log[i] == int'(mw & 12'h27F), "R5", "mode address",
                      a_log[i], int'(mw & 12'h27F));
        end
        check(done_idx == e_done, mf ? "R4" : "R7", "init_done cycle",
              done_idx, e_done);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        // Directed corners: zero clamp, back-to-back, maximum spacing, full wait
        run_case(0, 0, 0, 12'h020, 1'b0);
        run_case(1, 1, 1, 12'h033, 1'b1);
        run_case(3, 15, 15, 12'hFFF, 1'b0);
        run_case(2, 15, 15, 12'hD8A, 1'b1);
        run_case(40000, 3, 10, 12'h032, 1'b0);
        // Random cases
        for (int c = 0; c < 10; c++) begin
            run_case(int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
                     int'($urandom_range(0, 15)), ADDR_W'($urandom),
                     1'($urandom_range(0, 1)));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule